// File: doc/BRIEF.md
# Scanline Hardware Cursor Overlay

This block lays a 64x64 monochrome cursor over a stream of 32-bit display pixels. Each incoming pixel comes with its scanline number and its column index. When the pixel falls inside the cursor window, the block reads one mask bit and one flip bit for that pixel from a small byte-wide pattern memory. It then outputs one of four things: the pixel unchanged, its bitwise complement, or one of two opaque cursor colours. The pattern memory has its own write port, so the display controller or a test harness can load the cursor image.

Software writes pending copies of the base address, position, colours and enable through a simple select/data write port. The pending values move into the active set only on a frame-start pulse, so the cursor never changes halfway through a frame. A lock bit kept with the base address holds back every field except the enable. Once the lock is cleared, the next frame start applies all pending values together. Output pixels follow their inputs by exactly one clock, which is the latency of the synchronous pattern read.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the active enable is clear, `pix_valid_out` is low and every pixel leaves unchanged.
- R2: `pix_valid_out` repeats `pix_valid_in` one clock later, and `pix_out` in that cycle belongs to the pixel accepted one clock earlier.
- R3: Cursor row r starts at pattern byte base+16r (modulo the memory size). Bytes 0..7 of the row are the mask plane and bytes 8..15 are the flip plane. Byte i covers cursor columns 8i..8i+7, and its bit 7 maps to the lowest column.
- R4: mask=1, flip=1 outputs the bitwise complement of the 32-bit input pixel.
- R5: mask=1, flip=0 passes the input pixel unchanged.
- R6: mask=0 outputs {8'hFF, colour1} when flip=1 and {8'hFF, colour0} when flip=0. The colour registers keep only write-data bits 23:0.
- R7: The position write (select 1) takes column X from bits 29:16 and line Y from bits 11:0. Only lines Y..Y+63 and columns X..X+63 are overlaid, at cursor row line-Y and cursor column col-X.
- R8: No overlay happens while the active enable (select 4, bit 0) is clear, or on a line greater than `v_last`.
- R9: A cursor pixel whose column is equal to or greater than `h_width` is not overlaid.
- R10: Register writes (select 0 base, 1 position, 2 colour0, 3 colour1, 4 enable) only change the pending copies. The enable is applied at every `frame_start`, and the other fields are applied at `frame_start` when the lock is clear.
- R11: Bit 31 of the base write (select 0) is the lock. While it is set, `frame_start` leaves base, position and colours unchanged. Once a later write clears it, the next `frame_start` applies all pending values together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 base+lock, 1 position, 2 colour0, 3 colour1, 4 enable) |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Frame-start pulse; applies pending registers |
| h_width | input | 14 | Horizontal displayed width in pixels |
| v_last | input | 12 | Last displayed line |
| pat_we | input | 1 | Pattern memory write strobe |
| pat_addr | input | 10 | Pattern memory byte address |
| pat_wdata | input | 8 | Pattern memory write byte |
| pix_valid_in | input | 1 | Input pixel valid |
| pix_line | input | 12 | Scanline of the input pixel |
| pix_col | input | 14 | Column of the input pixel |
| pix_in | input | 32 | Underlying pixel value |
| pix_valid_out | output | 1 | Output pixel valid |
| pix_out | output | 32 | Pixel after overlay |

## Verification
The hardest case to reach is a frame start that arrives while the lock holds pending values back. The active registers cannot be observed directly, so the stimulus first sets up a known cursor. It then sets the lock, writes a new colour and position, pulses frame start, and checks that pixels still show the old cursor. After that it clears the lock and checks that one more frame start moves every field at once. Clipping and line-limit corners are reached by placing a directed pattern row across the `h_width` and `v_last` boundaries. Seeded random windows, pattern bytes and colours then sweep the rest of the space against a bench model of the cursor.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
  localparam int unsigned PIX_W = 32;
  localparam int unsigned CLR_W = 24;

  typedef enum logic [2:0] {
    SEL_BASE = 3'd0,
    SEL_POS  = 3'd1,
    SEL_CLR0 = 3'd2,
    SEL_CLR1 = 3'd3,
    SEL_CTRL = 3'd4
  } cfg_sel_e;

  // mask/flip decode of one cursor pixel over the underlying pixel
  function automatic logic [PIX_W-1:0] blend_pixel(
    input logic             mask_b,
    input logic             flip_b,
    input logic [PIX_W-1:0] under,
    input logic [CLR_W-1:0] clr0,
    input logic [CLR_W-1:0] clr1
  );
    if (mask_b) return flip_b ? ~under : under;
    return {{(PIX_W-CLR_W){1'b1}}, (flip_b ? clr1 : clr0)};
  endfunction
endpackage

// File: rtl/cursor_cfg_regs.sv
module cursor_cfg_regs
  import cursor_ovl_pkg::*;
#(
  parameter int unsigned COORD_W = 14,
  parameter int unsigned LINE_W  = 12,
  parameter int unsigned MEM_AW  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [31:0]        cfg_wdata,
  input  logic               frame_start,
  output logic               pend_lock,
  output logic               apply_now,
  output logic               act_en,
  output logic [MEM_AW-1:0]  act_base,
  output logic [COORD_W-1:0] act_x,
  output logic [LINE_W-1:0]  act_y,
  output logic [CLR_W-1:0]   act_c0,
  output logic [CLR_W-1:0]   act_c1
);
  localparam int unsigned X_LSB = 16;

  logic               pend_en;
  logic [MEM_AW-1:0]  pend_base;
  logic [COORD_W-1:0] pend_x;
  logic [LINE_W-1:0]  pend_y;
  logic [CLR_W-1:0]   pend_c0, pend_c1;

  assign apply_now = frame_start & ~pend_lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_en   <= 1'b0;
      pend_lock <= 1'b0;
      pend_base <= '0;
      pend_x    <= '0;
      pend_y    <= '0;
      pend_c0   <= '0;
      pend_c1   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_BASE: begin
          pend_lock <= cfg_wdata[31];
          pend_base <= cfg_wdata[MEM_AW-1:0];
        end
        SEL_POS: begin
          pend_x <= cfg_wdata[X_LSB +: COORD_W];
          pend_y <= cfg_wdata[LINE_W-1:0];
        end
        SEL_CLR0: pend_c0 <= cfg_wdata[CLR_W-1:0];
        SEL_CLR1: pend_c1 <= cfg_wdata[CLR_W-1:0];
        SEL_CTRL: pend_en <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_en   <= 1'b0;
      act_base <= '0;
      act_x    <= '0;
      act_y    <= '0;
      act_c0   <= '0;
      act_c1   <= '0;
    end else begin
      if (frame_start) act_en <= pend_en;
      if (apply_now) begin
        act_base <= pend_base;
        act_x    <= pend_x;
        act_y    <= pend_y;
        act_c0   <= pend_c0;
        act_c1   <= pend_c1;
      end
    end
  end
endmodule

// File: rtl/cursor_pattern_ram.sv
module cursor_pattern_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data_a <= mem[rd_addr_a];
    rd_data_b <= mem[rd_addr_b];
  end
endmodule

// File: rtl/cursor_pixel_pipe.sv
module cursor_pixel_pipe
  import cursor_ovl_pkg::*;
#(
  parameter int unsigned COORD_W  = 14,
  parameter int unsigned LINE_W   = 12,
  parameter int unsigned CUR_SIZE = 64,
  parameter int unsigned MEM_AW   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               act_en,
  input  logic [MEM_AW-1:0]  act_base,
  input  logic [COORD_W-1:0] act_x,
  input  logic [LINE_W-1:0]  act_y,
  input  logic [CLR_W-1:0]   act_c0,
  input  logic [CLR_W-1:0]   act_c1,
  input  logic [COORD_W-1:0] h_width,
  input  logic [LINE_W-1:0]  v_last,
  input  logic               in_valid,
  input  logic [LINE_W-1:0]  in_line,
  input  logic [COORD_W-1:0] in_col,
  input  logic [PIX_W-1:0]   in_pix,
  output logic [MEM_AW-1:0]  rd_addr_mask,
  output logic [MEM_AW-1:0]  rd_addr_flip,
  input  logic [7:0]         rd_mask_byte,
  input  logic [7:0]         rd_flip_byte,
  output logic               hit,
  output logic               out_valid,
  output logic [PIX_W-1:0]   out_pix
);
  localparam int unsigned IDX_W       = $clog2(CUR_SIZE);
  localparam int unsigned PLANE_BYTES = CUR_SIZE / 8;
  localparam int unsigned ROW_BYTES   = 2 * PLANE_BYTES;
  localparam int unsigned ROW_SH      = $clog2(ROW_BYTES);
  localparam logic [LINE_W:0]  SPAN_L = (LINE_W+1)'(CUR_SIZE);
  localparam logic [COORD_W:0] SPAN_C = (COORD_W+1)'(CUR_SIZE);

  logic [LINE_W:0]  dy;
  logic [COORD_W:0] dx;
  logic             in_rows, in_cols, line_shown, col_shown;
  logic [IDX_W-1:0] cur_row, cur_col;
  logic [MEM_AW-1:0] row_off, byte_off;

  assign dy = {1'b0, in_line} - {1'b0, act_y};
  assign dx = {1'b0, in_col}  - {1'b0, act_x};
  assign in_rows    = ~dy[LINE_W]  && (dy < SPAN_L);
  assign in_cols    = ~dx[COORD_W] && (dx < SPAN_C);
  assign line_shown = in_line <= v_last;
  assign col_shown  = in_col < h_width;
  assign hit = act_en & in_rows & in_cols & line_shown & col_shown;

  assign cur_row  = dy[IDX_W-1:0];
  assign cur_col  = dx[IDX_W-1:0];
  assign row_off  = MEM_AW'({cur_row, {ROW_SH{1'b0}}});
  assign byte_off = MEM_AW'(cur_col[IDX_W-1:3]);
  assign rd_addr_mask = act_base + row_off + byte_off;
  assign rd_addr_flip = rd_addr_mask + MEM_AW'(PLANE_BYTES);

  logic             s1_valid, s1_hit;
  logic [2:0]       s1_bit;
  logic [PIX_W-1:0] s1_pix;
  logic [CLR_W-1:0] s1_c0, s1_c1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_hit   <= 1'b0;
      s1_bit   <= '0;
      s1_pix   <= '0;
      s1_c0    <= '0;
      s1_c1    <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_hit   <= in_valid & hit;
      s1_bit   <= ~cur_col[2:0];
      s1_pix   <= in_pix;
      s1_c0    <= act_c0;
      s1_c1    <= act_c1;
    end
  end

  logic mask_b, flip_b;
  assign mask_b    = rd_mask_byte[s1_bit];
  assign flip_b    = rd_flip_byte[s1_bit];
  assign out_valid = s1_valid;
  assign out_pix   = s1_hit ? blend_pixel(mask_b, flip_b, s1_pix, s1_c0, s1_c1)
                            : s1_pix;
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_ovl_pkg::*;
#(
  parameter int unsigned COORD_W  = 14,
  parameter int unsigned LINE_W   = 12,
  parameter int unsigned CUR_SIZE = 64,
  parameter int unsigned MEM_AW   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [31:0]        cfg_wdata,
  input  logic               frame_start,
  input  logic [COORD_W-1:0] h_width,
  input  logic [LINE_W-1:0]  v_last,
  input  logic               pat_we,
  input  logic [MEM_AW-1:0]  pat_addr,
  input  logic [7:0]         pat_wdata,
  input  logic               pix_valid_in,
  input  logic [LINE_W-1:0]  pix_line,
  input  logic [COORD_W-1:0] pix_col,
  input  logic [31:0]        pix_in,
  output logic               pix_valid_out,
  output logic [31:0]        pix_out
);
  logic               pend_lock, apply_now;
  logic               act_en;
  logic [MEM_AW-1:0]  act_base;
  logic [COORD_W-1:0] act_x;
  logic [LINE_W-1:0]  act_y;
  logic [CLR_W-1:0]   act_c0, act_c1;
  logic [MEM_AW-1:0]  addr_mask, addr_flip;
  logic [7:0]         byte_mask, byte_flip;
  logic               ovl_hit;

  cursor_cfg_regs #(.COORD_W(COORD_W), .LINE_W(LINE_W), .MEM_AW(MEM_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start),
    .pend_lock(pend_lock), .apply_now(apply_now), .act_en(act_en),
    .act_base(act_base), .act_x(act_x), .act_y(act_y),
    .act_c0(act_c0), .act_c1(act_c1)
  );

  cursor_pattern_ram #(.AW(MEM_AW), .DW(8)) u_ram (
    .clk(clk), .wr_en(pat_we), .wr_addr(pat_addr), .wr_data(pat_wdata),
    .rd_addr_a(addr_mask), .rd_addr_b(addr_flip),
    .rd_data_a(byte_mask), .rd_data_b(byte_flip)
  );

  cursor_pixel_pipe #(.COORD_W(COORD_W), .LINE_W(LINE_W), .CUR_SIZE(CUR_SIZE),
                      .MEM_AW(MEM_AW)) u_pipe (
    .clk(clk), .rst_n(rst_n), .act_en(act_en), .act_base(act_base),
    .act_x(act_x), .act_y(act_y), .act_c0(act_c0), .act_c1(act_c1),
    .h_width(h_width), .v_last(v_last), .in_valid(pix_valid_in),
    .in_line(pix_line), .in_col(pix_col), .in_pix(pix_in),
    .rd_addr_mask(addr_mask), .rd_addr_flip(addr_flip),
    .rd_mask_byte(byte_mask), .rd_flip_byte(byte_flip),
    .hit(ovl_hit), .out_valid(pix_valid_out), .out_pix(pix_out)
  );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int unsigned COORD_W = 14,
  parameter int unsigned LINE_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               pend_lock,
  input logic               act_en,
  input logic [COORD_W-1:0] act_x,
  input logic [LINE_W-1:0]  act_y,
  input logic [23:0]        act_c0,
  input logic [23:0]        act_c1,
  input logic               ovl_hit,
  input logic               pix_valid_in,
  input logic [31:0]        pix_in,
  input logic               pix_valid_out,
  input logic [31:0]        pix_out
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_in |=> pix_valid_out) else $error("R2 valid not propagated");

  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid_in |=> !pix_valid_out) else $error("R2 spurious valid");

  a_r8_disabled_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_in && !act_en) |=> (pix_out == $past(pix_in)))
    else $error("R8 overlay while disabled");

  a_r7_outside_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_in && !ovl_hit) |=> (pix_out == $past(pix_in)))
    else $error("R7 pixel outside window altered");

  a_r10_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(act_x) && $stable(act_y) && $stable(act_c0)
                      && $stable(act_c1) && $stable(act_en)))
    else $error("R10 active state changed without frame start");

  a_r11_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && pend_lock) |=> ($stable(act_x) && $stable(act_y)
                                    && $stable(act_c0) && $stable(act_c1)))
    else $error("R11 locked state applied");
endmodule

bind cursor_overlay cursor_overlay_chk #(.COORD_W(COORD_W), .LINE_W(LINE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pend_lock(pend_lock),
  .act_en(act_en), .act_x(act_x), .act_y(act_y), .act_c0(act_c0),
  .act_c1(act_c1), .ovl_hit(ovl_hit), .pix_valid_in(pix_valid_in),
  .pix_in(pix_in), .pix_valid_out(pix_valid_out), .pix_out(pix_out)
);

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;
  localparam int CLK_PERIOD = 10;
  localparam int MEMD = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        frame_start = 1'b0;
  logic [13:0] h_width = 14'd640;
  logic [11:0] v_last = 12'd479;
  logic        pat_we = 1'b0;
  logic [9:0]  pat_addr = '0;
  logic [7:0]  pat_wdata = '0;
  logic        pix_valid_in = 1'b0;
  logic [11:0] pix_line = '0;
  logic [13:0] pix_col = '0;
  logic [31:0] pix_in = '0;
  logic        pix_valid_out;
  logic [31:0] pix_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  cursor_overlay i_cursor_overlay (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .h_width(h_width),
    .v_last(v_last), .pat_we(pat_we), .pat_addr(pat_addr),
    .pat_wdata(pat_wdata), .pix_valid_in(pix_valid_in), .pix_line(pix_line),
    .pix_col(pix_col), .pix_in(pix_in), .pix_valid_out(pix_valid_out),
    .pix_out(pix_out)
  );

  int n_checks = 0;
  int n_errors = 0;

  // bench model: pending and active cursor state, pattern bytes
  logic [7:0] bmem [MEMD];
  bit  p_en, p_lock, a_en;
  int  p_base, p_x, p_y, a_base, a_x, a_y;
  logic [23:0] p_c0, p_c1, a_c0, a_c1;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] want);
    n_checks++;
    if (got !== want) begin
      n_errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, want);
    end
  endtask

  function automatic logic [31:0] model_pix(int s, int x, logic [31:0] p);
    int r, c, a;
    bit m, f;
    if (!a_en || s > int'(v_last)) return p;
    if (s < a_y || s >= a_y + 64 || x < a_x || x >= a_x + 64) return p;
    if (x >= int'(h_width)) return p;
    r = s - a_y;
    c = x - a_x;
    a = (a_base + r * 16 + c / 8) % MEMD;
    m = bmem[a][7 - c % 8];
    f = bmem[(a + 8) % MEMD][7 - c % 8];
    if (m && f) return ~p;
    if (m) return p;
    return {8'hFF, f ? a_c1 : a_c0};
  endfunction

  task automatic wr_reg(input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      0: begin p_lock = d[31]; p_base = int'(d[9:0]); end
      1: begin p_x = int'(d[29:16]); p_y = int'(d[11:0]); end
      2: p_c0 = d[23:0];
      3: p_c1 = d[23:0];
      4: p_en = d[0];
      default: ;
    endcase
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    a_en = p_en;
    if (!p_lock) begin
      a_base = p_base; a_x = p_x; a_y = p_y; a_c0 = p_c0; a_c1 = p_c1;
    end
  endtask

  task automatic wr_pat(input int addr, input logic [7:0] d);
    @(negedge clk);
    pat_we = 1'b1; pat_addr = 10'(addr); pat_wdata = d;
    @(negedge clk);
    pat_we = 1'b0;
    bmem[addr % MEMD] = d;
  endtask

  task automatic px(input string tag, input int s, input int x, input logic [31:0] p);
    logic [31:0] want;
    want = model_pix(s, x, p);
    @(negedge clk);
    pix_valid_in = 1'b1; pix_line = 12'(s); pix_col = 14'(x); pix_in = p;
    @(posedge clk);
    @(negedge clk);
    pix_valid_in = 1'b0;
    if (pix_valid_out !== 1'b1) chk({tag, " valid"}, {31'd0, pix_valid_out}, 32'd1);
    chk(tag, pix_out, want);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7715));
    p_en = 0; p_lock = 0; a_en = 0;
    p_base = 0; p_x = 0; p_y = 0; a_base = 0; a_x = 0; a_y = 0;
    p_c0 = '0; p_c1 = '0; a_c0 = '0; a_c1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 valid low after reset", {31'd0, pix_valid_out}, 32'd0);
    px("R1 pass-through after reset", 0, 0, 32'h1234_5678);

    for (int i = 0; i < MEMD; i++) wr_pat(i, 8'($urandom));

    // directed pattern: base 0x040, row 0 and row 1
    wr_pat(16'h040 + 0,  8'b1100_0000); // mask byte0
    wr_pat(16'h040 + 8,  8'b1010_0000); // flip byte0
    wr_pat(16'h040 + 1,  8'h00);        // mask byte1
    wr_pat(16'h040 + 9,  8'h80);        // flip byte1
    wr_pat(16'h040 + 3,  8'h00);        // mask byte3
    wr_pat(16'h040 + 11, 8'h00);        // flip byte3
    wr_pat(16'h050 + 0,  8'hFF);        // row1 mask byte0
    wr_pat(16'h050 + 8,  8'hFF);        // row1 flip byte0

    wr_reg(0, 32'h0000_0040);
    wr_reg(1, {2'b0, 14'd100, 4'd0, 12'd50});
    wr_reg(2, 32'hAB12_3456);
    wr_reg(3, 32'hCD65_4321);
    wr_reg(4, 32'd1);

    // R10: nothing applied before frame start
    px("R10 pending not yet active", 50, 100, 32'h0F0F_0F0F);
    chk("R10 model still disabled", {31'd0, a_en}, 32'd0);
    frame();

    px("R4 complement", 50, 100, 32'h0F0F_00FF);
    chk("R4 explicit", pix_out, 32'hF0F0_FF00);
    px("R5 transparent", 50, 101, 32'h1357_9BDF);
    chk("R5 explicit", pix_out, 32'h1357_9BDF);
    px("R6 colour1", 50, 102, 32'h0);
    chk("R6 colour1 explicit", pix_out, 32'hFF65_4321);
    px("R6 colour0", 50, 103, 32'h0);
    chk("R6 colour0 explicit", pix_out, 32'hFF12_3456);
    px("R3 byte1 msb", 50, 108, 32'h0);
    chk("R3 byte1 msb explicit", pix_out, 32'hFF65_4321);
    px("R3 byte1 bit6", 50, 109, 32'h0);
    chk("R3 byte1 bit6 explicit", pix_out, 32'hFF12_3456);
    px("R3 row1 offset 16", 51, 100, 32'hAAAA_5555);
    chk("R3 row1 explicit", pix_out, 32'h5555_AAAA);

    // R7 window edges
    px("R7 line above", 49, 100, 32'h2222_2222);
    px("R7 last line", 113, 130, 32'h3333_3333);
    px("R7 line below", 114, 100, 32'h4444_4444);
    chk("R7 line below explicit", pix_out, 32'h4444_4444);
    px("R7 column left", 50, 99, 32'h5555_5555);
    px("R7 last column", 60, 163, 32'h6666_6666);
    px("R7 column right", 50, 164, 32'h7777_7777);

    // R2: idle cycle shows no valid
    @(negedge clk);
    chk("R2 valid low when idle", {31'd0, pix_valid_out}, 32'd0);

    // R9: clip at horizontal width
    h_width = 14'd130;
    px("R9 column below width", 50, 129, 32'h0);
    chk("R9 inside explicit", pix_out, 32'hFF12_3456);
    px("R9 column at width", 50, 130, 32'h0);
    chk("R9 clipped explicit", pix_out, 32'h0);
    h_width = 14'd640;

    // R8: line limit and enable
    v_last = 12'd50;
    px("R8 line at v_last", 50, 103, 32'h0);
    px("R8 line beyond v_last", 51, 100, 32'h8888_8888);
    chk("R8 beyond explicit", pix_out, 32'h8888_8888);
    v_last = 12'd479;
    wr_reg(4, 32'd0);
    frame();
    px("R8 disabled", 50, 100, 32'h9999_9999);
    chk("R8 disabled explicit", pix_out, 32'h9999_9999);
    wr_reg(4, 32'd1);
    frame();

    // R11: lock holds pending values through a frame start
    wr_reg(0, 32'h8000_0040);
    wr_reg(2, 32'h00AA_BBCC);
    wr_reg(1, {2'b0, 14'd300, 4'd0, 12'd200});
    frame();
    px("R11 locked keeps colour", 50, 103, 32'h0);
    chk("R11 locked explicit", pix_out, 32'hFF12_3456);
    wr_reg(0, 32'h0000_0040);
    px("R11 unlock waits for frame", 50, 103, 32'h0);
    frame();
    px("R11 old position released", 50, 103, 32'hABAB_ABAB);
    chk("R11 old position explicit", pix_out, 32'hABAB_ABAB);
    px("R11 new position and colour", 200, 303, 32'h0);

    // random configurations
    for (int k = 0; k < 6; k++) begin
      wr_reg(0, {22'd0, 10'($urandom)});
      wr_reg(1, {2'b0, 14'($urandom_range(0, 300)), 4'd0, 12'($urandom_range(0, 200))});
      wr_reg(2, $urandom);
      wr_reg(3, $urandom);
      wr_reg(4, {31'd0, (k != 3)});
      h_width = 14'($urandom_range(100, 400));
      v_last  = 12'($urandom_range(50, 300));
      frame();
      for (int n = 0; n < 200; n++)
        px("R7 random window", a_y - 4 + int'($urandom_range(0, 72)),
           a_x - 4 + int'($urandom_range(0, 72)), $urandom);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule